// File: doc/BRIEF.md
# Cacheline Read Link Bridge

The bridge sits between a processor cache controller and a word-wide memory port. The cache controller talks to it over two FIFO-style links. It writes a single request word that names the word address of a missed line. It then waits on a response link until the whole line has come back. The bridge fetches the line one word at a time over a plain read port that has acknowledge and error inputs. It pushes each word onto the response link as soon as that link has room.

Words come back critical-word-first. The missed word is sent first. The following words continue upward and wrap to the start of the aligned line. Every returned word carries a flag. A flag of 1 marks good data. A flag of 0 marks a word whose read reported an error or drew no acknowledge within a configurable number of cycles. A failed word does not end the line. The remaining words are still fetched and returned.

Addresses are word addresses. `LINE_WORDS` must be a power of two of at least 2, and `TIMEOUT_CYC` must be at least 1. The reset input is assumed to be already released in step with `clk`.

Top module: `line_fetch_bridge`

## Requirements
- R1: While reset is asserted and after it is released with no request present, `mem_rd`, `resp_push` and `req_pop` are all 0.
- R2: When the bridge is idle and `req_valid` is 1, it asserts `req_pop` in that same cycle, so the request word is taken at the next clock edge. A word taken with `req_ctrl` = 0 starts a line read, and its `req_data` is the missed word address.
- R3: A request word taken with `req_ctrl` = 1 is discarded. It causes no memory read and no response word, and the bridge stays ready for the next request.
- R4: For a request at address A, the bridge returns exactly `LINE_WORDS` response words. Word i (i = 0 upward) is read from the address whose bits above the line index equal those of A, and whose low log2(`LINE_WORDS`) bits equal (A + i) modulo `LINE_WORDS`.
- R5: `mem_rd` is held with a stable `mem_addr` until the read ends. If `mem_ack` = 1 and `mem_err` = 0 in a cycle where `mem_rd` = 1, that read ends, and its word is returned with `resp_ctrl` = 1 and `resp_data` equal to the `mem_rdata` of that cycle.
- R6: If `mem_err` = 1 in a cycle where `mem_rd` = 1, that read ends and its word is returned with `resp_ctrl` = 0 and `resp_data` = 0. This holds even when `mem_ack` is also 1.
- R7: If `mem_rd` has been high for `TIMEOUT_CYC` cycles with neither `mem_ack` nor `mem_err`, the read ends and the word is returned with `resp_ctrl` = 0 and `resp_data` = 0. An acknowledge in the `TIMEOUT_CYC`-th cycle is still accepted as valid data.
- R8: After a word fails by error or timeout, the remaining words of the line are still read and returned.
- R9: `resp_push` is never 1 while `resp_full` is 1. While a word waits for room, its data and flag are held, no further memory read is issued, and the word is pushed once room appears.
- R10: No new request is taken (`req_pop` stays 0) until every word of the current line has been pushed.
- R11: The timeout count restarts for every word read, so each word of a line may use up to `TIMEOUT_CYC` cycles of `mem_rd` and still return valid data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request word is present on the request link |
| req_ctrl | input | 1 | Control bit of the request word, 0 = line read |
| req_data | input | DATA_W | Data field of the request word, the missed word address |
| req_pop | output | 1 | Takes the current request word at the clock edge |
| mem_rd | output | 1 | Word read request to memory, held until the read ends |
| mem_addr | output | DATA_W | Word address of the current read |
| mem_ack | input | 1 | Memory acknowledge with data |
| mem_err | input | 1 | Memory error for the current read |
| mem_rdata | input | DATA_W | Memory read data |
| resp_full | input | 1 | Response link cannot take a word |
| resp_push | output | 1 | Writes one word to the response link |
| resp_ctrl | output | 1 | Response flag, 1 = valid data, 0 = error or timeout |
| resp_data | output | DATA_W | Response data word, 0 when the flag is 0 |

## Verification
The case hardest to reach from the ports is the edge of the timeout window. An acknowledge on the last permitted cycle must be accepted, and one a cycle later must be lost. Both can occur for different words of one line, sometimes while the response link is stalled. The bench memory model holds a table of behaviours, one per word index. Each entry gives a latency and one of four outcomes: good data, error, error together with acknowledge, or silence. Directed lines set latencies of exactly `TIMEOUT_CYC`-1 and `TIMEOUT_CYC`. Random lines then mix all outcomes with random response-link stalls.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_PUSH = 2'd2
  } lfb_state_e;

endpackage

// File: rtl/lfb_rd_timer.sv
// Ends each memory word read: acknowledge, error or expiry of the wait window.
module lfb_rd_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic mem_ack,
  input  logic mem_err,
  output logic rd_done,
  output logic rd_ok
);

  logic expire;
  logic hit;

  assign hit     = mem_ack | mem_err;
  assign rd_done = rd_en & (hit | expire);
  assign rd_ok   = rd_en & mem_ack & ~mem_err;

  generate
    if (TIMEOUT_CYC > 1) begin : g_count
      localparam int CW = $clog2(TIMEOUT_CYC);
      localparam logic [CW-1:0] LAST_CYC = CW'(TIMEOUT_CYC - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_en;

      assign expire = (cnt_q == LAST_CYC);

      always_comb begin
        cnt_en = 1'b1;
        if (rd_en && !rd_done) begin
          cnt_d = cnt_q + CW'(1);
        end else begin
          cnt_d = '0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end
    end else begin : g_single
      assign expire = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/lfb_resp_hold.sv
// One-word holding register in front of the response link.
module lfb_resp_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              cap_ok,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              resp_full,
  output logic              resp_push,
  output logic              resp_ctrl,
  output logic [DATA_W-1:0] resp_data,
  output logic              hold_vld
);

  logic              vld_q;
  logic              vld_d;
  logic              ok_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  assign resp_push = vld_q & ~resp_full;
  assign resp_ctrl = ok_q;
  assign resp_data = data_q;
  assign hold_vld  = vld_q;

  always_comb begin
    vld_d = vld_q;
    if (cap) begin
      vld_d = 1'b1;
    end else if (resp_push) begin
      vld_d = 1'b0;
    end
    data_d = cap_ok ? cap_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      ok_q   <= cap_ok;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/lfb_ctrl.sv
// Request intake, line sequencing and wrapped word addressing.
module lfb_ctrl
  import lfb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ctrl,
  input  logic [DATA_W-1:0] req_addr,
  input  logic              rd_done,
  input  logic              push_fire,
  output logic              req_pop,
  output logic              rd_en,
  output logic [DATA_W-1:0] word_addr
);

  localparam int IDX_W = $clog2(LINE_WORDS);
  localparam int TAG_W = DATA_W - IDX_W;
  localparam logic [IDX_W-1:0] LAST_W = IDX_W'(LINE_WORDS - 1);

  lfb_state_e       state_q;
  lfb_state_e       state_d;
  logic [TAG_W-1:0] line_q;
  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] wcnt_q;
  logic [IDX_W-1:0] wcnt_d;
  logic [IDX_W-1:0] idx;
  logic             idle;
  logic             accept;
  logic             last_word;
  logic             wcnt_en;

  assign idle      = (state_q == ST_IDLE);
  assign req_pop   = idle & req_valid;
  assign accept    = req_pop & ~req_ctrl;
  assign rd_en     = (state_q == ST_READ);
  assign last_word = (wcnt_q == LAST_W);
  assign idx       = start_q + wcnt_q;
  assign word_addr = {line_q, idx};

  always_comb begin
    state_d = state_q;
    wcnt_en = 1'b0;
    wcnt_d  = wcnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_READ;
          wcnt_en = 1'b1;
          wcnt_d  = '0;
        end
      end
      ST_READ: begin
        if (rd_done) begin
          state_d = ST_PUSH;
        end
      end
      ST_PUSH: begin
        if (push_fire) begin
          if (last_word) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_READ;
            wcnt_en = 1'b1;
            wcnt_d  = wcnt_q + IDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      line_q  <= req_addr[DATA_W-1:IDX_W];
      start_q <= req_addr[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wcnt_en) begin
      wcnt_q <= wcnt_d;
    end
  end

endmodule

// File: rtl/line_fetch_bridge.sv
module line_fetch_bridge #(
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 4,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ctrl,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_pop,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              resp_full,
  output logic              resp_push,
  output logic              resp_ctrl,
  output logic [DATA_W-1:0] resp_data
);

  logic rd_done;
  logic rd_ok;
  logic hold_vld;

  lfb_ctrl #(
    .DATA_W     (DATA_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ctrl  (req_ctrl),
    .req_addr  (req_data),
    .rd_done   (rd_done),
    .push_fire (resp_push),
    .req_pop   (req_pop),
    .rd_en     (mem_rd),
    .word_addr (mem_addr)
  );

  lfb_rd_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (mem_rd),
    .mem_ack (mem_ack),
    .mem_err (mem_err),
    .rd_done (rd_done),
    .rd_ok   (rd_ok)
  );

  lfb_resp_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (rd_done),
    .cap_ok    (rd_ok),
    .cap_data  (mem_rdata),
    .resp_full (resp_full),
    .resp_push (resp_push),
    .resp_ctrl (resp_ctrl),
    .resp_data (resp_data),
    .hold_vld  (hold_vld)
  );

endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 4,
  parameter int TIMEOUT_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ctrl,
  input logic              req_pop,
  input logic              mem_rd,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              resp_full,
  input logic              resp_push,
  input logic              resp_ctrl,
  input logic [DATA_W-1:0] resp_data,
  input logic              hold_vld
);

  localparam int RW = $clog2(LINE_WORDS + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 2);

  logic [RW-1:0] rem_q;
  logic [TW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (req_pop && req_valid && !req_ctrl) begin
      rem_q <= RW'(LINE_WORDS);
    end else if (resp_push && rem_q != '0) begin
      rem_q <= rem_q - RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!mem_rd) begin
      run_q <= '0;
    end else if (run_q != {TW{1'b1}}) begin
      run_q <= run_q + TW'(1);
    end
  end

  AST_PUSH_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_push |-> rem_q != '0); // R4
  AST_NO_POP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |-> rem_q == '0); // R10
  AST_DROP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop && req_valid && req_ctrl) |=> !mem_rd); // R3
  AST_READ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && (mem_ack || mem_err)) |=> !mem_rd); // R5
  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_push && !resp_ctrl) |-> resp_data == '0); // R6
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> run_q < TW'(TIMEOUT_CYC)); // R7
  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    resp_full |-> !resp_push); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && resp_full) |=> (hold_vld && !mem_rd && $stable(resp_data) && $stable(resp_ctrl))); // R9

endmodule

bind line_fetch_bridge lfb_checker #(
  .DATA_W      (DATA_W),
  .LINE_WORDS  (LINE_WORDS),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ctrl  (req_ctrl),
  .req_pop   (req_pop),
  .mem_rd    (mem_rd),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err),
  .resp_full (resp_full),
  .resp_push (resp_push),
  .resp_ctrl (resp_ctrl),
  .resp_data (resp_data),
  .hold_vld  (hold_vld)
);

// File: tb/sim_line_fetch_bridge.sv
module sim_line_fetch_bridge;

  localparam int DW = 32;
  localparam int LW = 4;
  localparam int IW = 2;
  localparam int TO = 16;

  typedef struct packed {
    logic [1:0]    tag;
    logic          ctrl;
    logic [DW-1:0] data;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ctrl;
  logic [DW-1:0] req_data;
  logic          req_pop;
  logic          mem_rd;
  logic [DW-1:0] mem_addr;
  logic          mem_ack;
  logic          mem_err;
  logic [DW-1:0] mem_rdata;
  logic          resp_full;
  logic          resp_push;
  logic          resp_ctrl;
  logic [DW-1:0] resp_data;

  int   checks;
  int   errors;
  int   plan_mode [LW];
  int   plan_lat  [LW];
  exp_t exp_q [$];
  bit   pop_flag;
  bit   done;
  bit   force_full;
  int   full_pct;
  int   rd_cycles;
  int   push_total;
  int   waited;

  line_fetch_bridge #(
    .DATA_W      (DW),
    .LINE_WORDS  (LW),
    .TIMEOUT_CYC (TO)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ctrl  (req_ctrl),
    .req_data  (req_data),
    .req_pop   (req_pop),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .resp_full (resp_full),
    .resp_push (resp_push),
    .resp_ctrl (resp_ctrl),
    .resp_data (resp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [DW-1:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[31:16]};
  endfunction

  function automatic logic [DW-1:0] order_addr(input logic [DW-1:0] a, input int i);
    logic [DW-1:0] msk;
    msk = DW'(LW - 1);
    return (a & ~msk) | ((a + DW'(i)) & msk);
  endfunction

  function automatic string tag_name(input logic [1:0] t);
    case (t)
      2'd0:    return "R5";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and response-link fullness, driven at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_err   <= 1'b0;
      mem_rdata <= '0;
      waited    = 0;
      resp_full <= 1'b0;
    end else begin
      if (mem_rd) begin
        int ix;
        int m;
        bit fire;
        ix   = int'(mem_addr[IW-1:0]);
        m    = plan_mode[ix];
        fire = (waited == plan_lat[ix]);
        mem_ack   <= fire && (m == 0 || m == 3);
        mem_err   <= fire && (m == 1 || m == 3);
        mem_rdata <= fire && m == 0 ? mem_val(mem_addr) : DW'($urandom);
        waited++;
      end else begin
        mem_ack   <= 1'b0;
        mem_err   <= 1'b0;
        mem_rdata <= DW'($urandom);
        waited    = 0;
      end
      resp_full <= force_full || (full_pct > 0 && int'($urandom % 100) < full_pct);
    end
  end

  // monitor, sampling away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (mem_rd) rd_cycles++;
      if (req_valid && req_pop) begin
        pop_flag = 1'b1;
        chk(exp_q.size() == 0, "R10", "request taken while line busy",
            longint'(exp_q.size()), 0);
        if (!req_ctrl) begin
          for (int i = 0; i < LW; i++) begin
            logic [DW-1:0] a;
            exp_t e;
            int   ix;
            bit   ok;
            a  = order_addr(req_data, i);
            ix = int'(a[IW-1:0]);
            ok = (plan_mode[ix] == 0) && (plan_lat[ix] < TO);
            e.ctrl = ok;
            e.data = ok ? mem_val(a) : '0;
            if (plan_mode[ix] == 1 || plan_mode[ix] == 3) e.tag = 2'd1;
            else if (!ok)                                 e.tag = 2'd2;
            else if (plan_lat[ix] == TO - 1)              e.tag = 2'd3;
            else                                          e.tag = 2'd0;
            exp_q.push_back(e);
          end
        end
      end
      if (resp_push) begin
        push_total++;
        chk(!resp_full, "R9", "push while full", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected response word", longint'(resp_data), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(resp_ctrl == e.ctrl && resp_data == e.data, tag_name(e.tag),
              "response word {ctrl,data}", longint'({resp_ctrl, resp_data}),
              longint'({e.ctrl, e.data}));
        end
      end
    end
  end

  task automatic send(input logic c, input logic [DW-1:0] d, output int waits);
    @(negedge clk);
    req_valid = 1'b1;
    req_ctrl  = c;
    req_data  = d;
    pop_flag  = 1'b0;
    waits     = 0;
    forever begin
      @(posedge clk);
      waits++;
      if (pop_flag || waits > 5000) break;
    end
    pop_flag = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 10000) begin
      @(posedge clk);
      n++;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic set_plan(input int m0, input int l0, input int m1, input int l1,
                          input int m2, input int l2, input int m3, input int l3);
    plan_mode[0] = m0; plan_lat[0] = l0;
    plan_mode[1] = m1; plan_lat[1] = l1;
    plan_mode[2] = m2; plan_lat[2] = l2;
    plan_mode[3] = m3; plan_lat[3] = l3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    int wb;
    int p0;
    int r0;
    int seed;
    checks = 0; errors = 0; done = 1'b0; pop_flag = 1'b0;
    force_full = 1'b0; full_pct = 0; rd_cycles = 0; push_total = 0; waited = 0;
    seed = $urandom(32'd6173);
    rst_n = 1'b0; req_valid = 1'b0; req_ctrl = 1'b0; req_data = '0;
    set_plan(0, 0, 0, 0, 0, 0, 0, 0);

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!mem_rd && !resp_push && !req_pop, "R1", "outputs in reset",
        longint'({mem_rd, resp_push, req_pop}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!mem_rd && !resp_push && !req_pop, "R1", "outputs after reset",
        longint'({mem_rd, resp_push, req_pop}), 0);

    // R2, R4: aligned line, fast memory
    p0 = push_total;
    send(1'b0, 32'h0000_1000, w);
    chk(w == 1, "R2", "edges until request taken", longint'(w), 1);
    drain();
    chk(push_total - p0 == LW, "R4", "words per line", longint'(push_total - p0), LW);

    // R4: wrap from the last word of the line
    set_plan(0, 2, 0, 0, 0, 3, 0, 1);
    p0 = push_total;
    send(1'b0, 32'h0000_2003, w);
    drain();
    chk(push_total - p0 == LW, "R4", "words per wrapped line", longint'(push_total - p0), LW);

    // R6, R7, R8: error, silence and error-with-ack inside one line
    set_plan(0, TO - 1, 1, 2, 2, 0, 3, 0);
    p0 = push_total;
    send(1'b0, 32'h0000_3001, w);
    drain();
    chk(push_total - p0 == LW, "R8", "words after failures", longint'(push_total - p0), LW);

    // R7: ack on the last allowed cycle and one cycle late
    set_plan(0, TO - 1, 0, TO, 0, TO - 1, 0, 0);
    send(1'b0, 32'h0000_4002, w);
    drain();

    // R11: every word at the longest accepted latency
    set_plan(0, TO - 1, 0, TO - 1, 0, TO - 1, 0, TO - 1);
    send(1'b0, 32'h0000_5000, w);
    drain();

    // R3: control bit set, word dropped
    set_plan(0, 0, 0, 0, 0, 0, 0, 0);
    r0 = rd_cycles; p0 = push_total;
    send(1'b1, 32'h0000_6000, w);
    repeat (30) @(negedge clk);
    #2;
    chk(w == 1, "R3", "dropped word taken", longint'(w), 1);
    chk(rd_cycles == r0, "R3", "memory cycles after drop", longint'(rd_cycles - r0), 0);
    chk(push_total == p0, "R3", "responses after drop", longint'(push_total - p0), 0);
    p0 = push_total;
    send(1'b0, 32'h0000_6002, w);
    drain();
    chk(push_total - p0 == LW, "R3", "line after drop", longint'(push_total - p0), LW);

    // R9: response link held full
    set_plan(0, 1, 0, 1, 0, 1, 0, 1);
    @(negedge clk);
    force_full = 1'b1;
    r0 = rd_cycles; p0 = push_total;
    send(1'b0, 32'h0000_7001, w);
    repeat (40) @(negedge clk);
    #2;
    chk(push_total == p0, "R9", "pushes while full", longint'(push_total - p0), 0);
    chk(rd_cycles - r0 == 2, "R9", "memory cycles while stalled", longint'(rd_cycles - r0), 2);
    force_full = 1'b0;
    drain();
    chk(push_total - p0 == LW, "R9", "words after stall", longint'(push_total - p0), LW);

    // R10: second request presented while busy
    set_plan(0, 2, 0, 2, 0, 2, 0, 2);
    send(1'b0, 32'h0000_8000, w);
    send(1'b0, 32'h0000_8003, wb);
    chk(wb > 2 * LW, "R10", "wait of second request", longint'(wb), 2 * LW);
    drain();

    // random mix
    full_pct = 30;
    for (int n = 0; n < 60; n++) begin
      logic          c;
      logic [DW-1:0] a;
      for (int i = 0; i < LW; i++) begin
        int r;
        r = int'($urandom % 10);
        plan_lat[i] = int'($urandom % 6);
        if (r < 6)       plan_mode[i] = 0;
        else if (r == 6) plan_mode[i] = 1;
        else if (r == 7) plan_mode[i] = 2;
        else if (r == 8) plan_mode[i] = 3;
        else begin
          plan_mode[i] = 0;
          plan_lat[i]  = TO - 1;
        end
      end
      c = ($urandom % 10) == 0;
      a = DW'($urandom);
      send(c, a, w);
      drain();
    end
    full_pct = 0;
    repeat (5) @(negedge clk);
    #2;
    chk(exp_q.size() == 0, "R4", "words left unreturned", longint'(exp_q.size()), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule